// File: doc/BRIEF.md
# Stereo Serial Audio Capture Receiver

This block receives a two-channel serial audio stream in the common I2S framing. A word-select line marks the left slot (low) and the right slot (high), and each sample is sent MSB first, one bit clock after the word-select change. The block can produce the bit clock and word select itself (master build, `IS_MASTER=1`), or it can follow external ones (slave build). In a slave build the inputs are synchronized to the system clock.

Each received sample is cut to a programmable resolution and stored right-justified. Left/right pairs go into a 16-frame circular capture memory. Software reads that memory through a single-cycle bus slave port. The memory works as a ping-pong buffer: one status bit reports that the lower eight frames are full, and another reports that the upper eight are full. Software can drain one half while the other half fills. The status bits are cleared by writing a one, and each can be masked onto a single interrupt line.

Top module: `stereo_capture_rx`

## Requirements
- R1: The register offsets are as follows.
  - Offset 0 reads 0x1B1 in a master build and 0x191 in a slave build.
  - Offset 1 is the config register. Bit 0 is enable and bits 23:16 are the resolution; both read back, and all other bits read 0.
  - Offset 2 is the mask, bits 1:0.
  - Offset 3 is the status, bits 1:0.
- R2: A request (cyc and stb high) is acknowledged by `bus_ack_o` high for exactly one cycle, in the cycle after the request is seen. Read data is valid with the acknowledge.
- R3: After reset, the following all read or sit at 0: config, mask, status, `irq_o`, `sck_o` and `ws_o`.
- R4: In a master build with capture enabled:
  - `sck_o` has a period of 2*SCK_HALF system clocks.
  - `ws_o` changes only on a falling `sck_o` edge, once every SLOT_BITS bit clocks.
  - `sd_i` is sampled at each rising `sck_o` edge.
- R5: In a slave build, `sck_i`, `ws_i` and `sd_i` pass through two-stage synchronizers. Data is sampled at each rising edge of the synchronized `sck_i`.
- R6: A slot starts one bit clock after a word-select change. Its first RES bits (RES = config bits 23:16) are taken MSB first and stored right-justified, with the bits above them zero. Later bits in the slot are ignored.
- R7: Frame j (0..15) stores its left word at offset 0x20+2j and its right word at offset 0x20+2j+1. After frame 15, storage wraps to frame 0.
- R8: The block discards two kinds of slot:
  - the first slot seen after enable (it may be partial);
  - a right slot with no stored left slot before it.
- R9: Status bit 0 sets when the right word of frame 7 is stored. Status bit 1 sets when the right word of frame 15 is stored.
- R10: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R11: `irq_o` is high exactly when a status bit is set while its mask bit is 1. A status bit whose mask bit is 0 does not raise the line.
- R12: While enable is 0, the block stores nothing and the master bit clock and word select are held low. Setting enable restarts storage at frame 0.
- R13: Writes to the capture memory region are ignored. Reads return the last stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_cyc_i | input | 1 | Bus cycle valid |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | Write enable |
| bus_adr_i | input | 6 | Word offset (IDX_W+1 bits) |
| bus_dat_i | input | 32 | Write data |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| bus_dat_o | output | 32 | Read data |
| irq_o | output | 1 | Masked half-full interrupt |
| sck_i | input | 1 | External bit clock (slave build) |
| ws_i | input | 1 | External word select (slave build) |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Generated bit clock (master build, else 0) |
| ws_o | output | 1 | Generated word select (master build, else 0) |

## Verification
The master build is tested with a transmitter model that runs at 24-bit resolution and follows the generated clocks. It fills both halves, wraps around, and is then disabled and re-enabled. The 0x20 word read after the wrap and the one read after re-enable tell a wrapping pointer apart from a restarting one. Every slot carries ones beyond the resolution, so the stored words show whether tail bits are ignored. The master run also shows whether the first partial slot and an orphan right slot are dropped: frame 0 must hold the second transmitted frame. The slave build is tested at 16-bit resolution, with values that have bits set above bit 15, and with the mask held at zero; this checks zero fill, masking and the ignored buffer write.

// File: rtl/stcap_pkg.sv
package stcap_pkg;
  localparam int DATA_W   = 32;
  localparam int RES_W    = 8;
  localparam int REG_VER  = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_MASK = 2;
  localparam int REG_STAT = 3;

  function automatic logic [DATA_W-1:0] version_word(input bit master);
    return master ? 32'h0000_01B1 : 32'h0000_0191;
  endfunction
endpackage

// File: rtl/stcap_bit_front.sv
module stcap_bit_front #(
  parameter bit IS_MASTER = 1'b1,
  parameter int SCK_HALF  = 2,
  parameter int SLOT_BITS = 32,
  localparam int DIV_W = $clog2(SCK_HALF) + 1,
  localparam int BIT_W = $clog2(SLOT_BITS) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic sck_o,
  output logic ws_o,
  output logic bit_stb_o,
  output logic bit_ws_o,
  output logic bit_sd_o
);
  if (IS_MASTER) begin : g_master
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bitc_q;
    logic             sck_q, ws_q;
    logic             unused_ext;
    assign unused_ext = sck_i ^ ws_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q <= '0; bitc_q <= '0; sck_q <= 1'b0; ws_q <= 1'b0;
      end else if (!run_i) begin
        div_q <= '0; bitc_q <= '0; sck_q <= 1'b0; ws_q <= 1'b0;
      end else if (div_q == DIV_W'(SCK_HALF-1)) begin
        div_q <= '0;
        sck_q <= ~sck_q;
        if (sck_q) begin  // falling edge: word select moves here
          if (bitc_q == BIT_W'(SLOT_BITS-1)) begin
            bitc_q <= '0;
            ws_q   <= ~ws_q;
          end else begin
            bitc_q <= bitc_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end

    assign sck_o     = sck_q;
    assign ws_o      = ws_q;
    assign bit_stb_o = run_i && (div_q == DIV_W'(SCK_HALF-1)) && !sck_q;
    assign bit_ws_o  = ws_q;
    assign bit_sd_o  = sd_i;

    // R4
    ws_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ws_q) |-> !sck_q);
    // R4
    stb_then_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_stb_o |=> sck_q);
  end else begin : g_slave
    logic [1:0] sck_s, ws_s, sd_s;
    logic       sck_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sck_s <= '0; ws_s <= '0; sd_s <= '0; sck_d <= 1'b0;
      end else begin
        sck_s <= {sck_s[0], sck_i};
        ws_s  <= {ws_s[0], ws_i};
        sd_s  <= {sd_s[0], sd_i};
        sck_d <= sck_s[1];
      end
    end

    assign sck_o     = 1'b0;
    assign ws_o      = 1'b0;
    assign bit_stb_o = run_i && sck_s[1] && !sck_d;
    assign bit_ws_o  = ws_s[1];
    assign bit_sd_o  = sd_s[1];

    // R5
    rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_stb_o |=> !bit_stb_o);
  end
endmodule

// File: rtl/stcap_slot_deser.sv
module stcap_slot_deser
  import stcap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              bit_stb_i,
  input  logic              bit_ws_i,
  input  logic              bit_sd_i,
  output logic              word_vld_o,
  output logic              word_right_o,
  output logic [DATA_W-1:0] word_o
);
  logic              primed_q, synced_q, ws_d_q;
  logic [5:0]        cnt_q;
  logic [DATA_W-1:0] shreg_q, shreg_nxt;
  logic              take;

  assign take      = {2'b00, cnt_q} < res_i;
  assign shreg_nxt = take ? {shreg_q[DATA_W-2:0], bit_sd_i} : shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0; synced_q <= 1'b0; ws_d_q <= 1'b0;
      cnt_q <= '0; shreg_q <= '0;
      word_vld_o <= 1'b0; word_right_o <= 1'b0; word_o <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (!run_i) begin
        primed_q <= 1'b0; synced_q <= 1'b0; cnt_q <= '0; shreg_q <= '0;
      end else if (bit_stb_i) begin
        if (!primed_q) begin
          primed_q <= 1'b1;
          ws_d_q   <= bit_ws_i;
        end else if (bit_ws_i != ws_d_q) begin
          // this bit is still the tail of the old slot
          ws_d_q       <= bit_ws_i;
          synced_q     <= 1'b1;
          word_vld_o   <= synced_q;
          word_right_o <= ws_d_q;
          word_o       <= shreg_nxt;
          cnt_q        <= '0;
          shreg_q      <= '0;
        end else begin
          shreg_q <= shreg_nxt;
          if (cnt_q != 6'h3F) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6
  right_just_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && (res_i < RES_W'(DATA_W))) |-> ((word_o >> res_i) == '0));
  // R8
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/stcap_frame_store.sv
module stcap_frame_store
  import stcap_pkg::*;
#(
  parameter int FRAMES = 16,
  localparam int FR_W  = $clog2(FRAMES),
  localparam int IDX_W = FR_W + 1,
  localparam int WORDS = 2 * FRAMES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_vld_i,
  input  logic              wr_right_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              half_lo_o,
  output logic              half_hi_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [FR_W-1:0]   frame_q;
  logic              left_seen_q;
  logic              we;
  logic [IDX_W-1:0]  waddr;

  assign we    = run_i && wr_vld_i && (!wr_right_i || left_seen_q);
  assign waddr = {frame_q, wr_right_i};

  always_ff @(posedge clk_i) begin
    if (we) mem_q[waddr] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0; left_seen_q <= 1'b0; half_lo_o <= 1'b0; half_hi_o <= 1'b0;
    end else begin
      half_lo_o <= 1'b0;
      half_hi_o <= 1'b0;
      if (!run_i) begin
        frame_q <= '0; left_seen_q <= 1'b0;
      end else if (we) begin
        if (!wr_right_i) begin
          left_seen_q <= 1'b1;
        end else begin
          left_seen_q <= 1'b0;
          frame_q     <= frame_q + 1'b1;
          half_lo_o   <= (frame_q == FR_W'(FRAMES/2 - 1));
          half_hi_o   <= (frame_q == FR_W'(FRAMES - 1));
        end
      end
    end
  end

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!half_lo_o && !half_hi_o && frame_q == '0));
  // R9
  half_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({half_lo_o, half_hi_o}));
endmodule

// File: rtl/stereo_capture_rx.sv
module stereo_capture_rx
  import stcap_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int SCK_HALF  = 2,
  parameter int SLOT_BITS = 32,
  parameter int FRAMES    = 16,
  localparam int IDX_W = $clog2(2 * FRAMES),
  localparam int ADR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cyc_i,
  input  logic              bus_stb_i,
  input  logic              bus_we_i,
  input  logic [ADR_W-1:0]  bus_adr_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  output logic              bus_ack_o,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic              irq_o,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              sck_o,
  output logic              ws_o
);
  logic              ack_q;
  logic [DATA_W-1:0] rdat_q, rd_mux;
  logic              cfg_en_q;
  logic [RES_W-1:0]  cfg_res_q;
  logic [1:0]        mask_q, sts_q, sts_clr;
  logic              hit, wr, buf_sel;
  logic              wr_cfg, wr_mask, wr_sts;
  logic [IDX_W-1:0]  loc;

  logic              bit_stb, bit_ws, bit_sd;
  logic              word_vld, word_right;
  logic [DATA_W-1:0] word, mem_rd;
  logic              half_lo, half_hi;
  logic              unused_bits;

  assign unused_bits = ^{bus_dat_i[DATA_W-1:24], bus_dat_i[15:2]};

  assign hit     = bus_cyc_i && bus_stb_i && !ack_q;
  assign wr      = hit && bus_we_i;
  assign buf_sel = bus_adr_i[ADR_W-1];
  assign loc     = bus_adr_i[IDX_W-1:0];
  assign wr_cfg  = wr && !buf_sel && (loc == IDX_W'(REG_CFG));
  assign wr_mask = wr && !buf_sel && (loc == IDX_W'(REG_MASK));
  assign wr_sts  = wr && !buf_sel && (loc == IDX_W'(REG_STAT));
  assign sts_clr = wr_sts ? bus_dat_i[1:0] : 2'b00;

  stcap_bit_front #(
    .IS_MASTER(IS_MASTER), .SCK_HALF(SCK_HALF), .SLOT_BITS(SLOT_BITS)
  ) u_front (
    .clk_i, .rst_ni, .run_i(cfg_en_q),
    .sck_i, .ws_i, .sd_i, .sck_o, .ws_o,
    .bit_stb_o(bit_stb), .bit_ws_o(bit_ws), .bit_sd_o(bit_sd)
  );

  stcap_slot_deser u_deser (
    .clk_i, .rst_ni, .run_i(cfg_en_q), .res_i(cfg_res_q),
    .bit_stb_i(bit_stb), .bit_ws_i(bit_ws), .bit_sd_i(bit_sd),
    .word_vld_o(word_vld), .word_right_o(word_right), .word_o(word)
  );

  stcap_frame_store #(.FRAMES(FRAMES)) u_store (
    .clk_i, .rst_ni, .run_i(cfg_en_q),
    .wr_vld_i(word_vld), .wr_right_i(word_right), .wr_data_i(word),
    .rd_idx_i(loc), .rd_data_o(mem_rd),
    .half_lo_o(half_lo), .half_hi_o(half_hi)
  );

  always_comb begin
    rd_mux = '0;
    if (buf_sel) begin
      rd_mux = mem_rd;
    end else begin
      case (loc)
        IDX_W'(REG_VER):  rd_mux = version_word(IS_MASTER);
        IDX_W'(REG_CFG):  rd_mux = {8'h00, cfg_res_q, 15'h0000, cfg_en_q};
        IDX_W'(REG_MASK): rd_mux = {30'h0, mask_q};
        IDX_W'(REG_STAT): rd_mux = {30'h0, sts_q};
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0; rdat_q <= '0;
      cfg_en_q <= 1'b0; cfg_res_q <= '0; mask_q <= '0; sts_q <= '0;
    end else begin
      ack_q <= hit;
      if (hit) rdat_q <= rd_mux;
      if (wr_cfg) begin
        cfg_en_q  <= bus_dat_i[0];
        cfg_res_q <= bus_dat_i[23:16];
      end
      if (wr_mask) mask_q <= bus_dat_i[1:0];
      sts_q <= (sts_q & ~sts_clr) | {half_hi, half_lo};
    end
  end

  assign bus_ack_o = ack_q;
  assign bus_dat_o = rdat_q;
  assign irq_o     = |(sts_q & mask_q);

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  // R10
  sts_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && bus_dat_i[0] && !half_lo) |=> !sts_q[0]);
  // R10
  sts_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_hi |=> sts_q[1]);
  // R11
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 2'b00) |-> !irq_o);
endmodule

// File: tb/stereo_capture_rx_test.sv
module stereo_capture_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 2;
  localparam int SLOT_BITS  = 32;
  localparam int S_HALF     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [5:0]  adr = '0;
  logic [31:0] wdat = '0;
  int          sel = 0;
  logic        m_ack, s_ack, m_irq, s_irq, m_sck, m_ws, s_sck_o, s_ws_o;
  logic [31:0] m_dat, s_dat;
  logic        m_sd = 1'b1, s_sck = 1'b0, s_ws = 1'b1, s_sd = 1'b1;

  int checks = 0, errors = 0;
  int tx_n = 0, tx_p = 0, tx_res = 24;
  logic tx_ws = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_capture_rx #(.IS_MASTER(1'b1), .SCK_HALF(SCK_HALF), .SLOT_BITS(SLOT_BITS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_cyc_i(cyc), .bus_stb_i(stb && sel == 0),
    .bus_we_i(we), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_ack_o(m_ack),
    .bus_dat_o(m_dat), .irq_o(m_irq), .sck_i(1'b0), .ws_i(1'b0), .sd_i(m_sd),
    .sck_o(m_sck), .ws_o(m_ws));

  stereo_capture_rx #(.IS_MASTER(1'b0)) uut_s (
    .clk_i(clk), .rst_ni(rst_n), .bus_cyc_i(cyc), .bus_stb_i(stb && sel == 1),
    .bus_we_i(we), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_ack_o(s_ack),
    .bus_dat_o(s_dat), .irq_o(s_irq), .sck_i(s_sck), .ws_i(s_ws), .sd_i(s_sd),
    .sck_o(s_sck_o), .ws_o(s_ws_o));

  function automatic logic [31:0] raw(input int f, input int ch);
    return (ch != 0 ? 32'h00C5_A3E1 : 32'h0071_2B4D) + 32'(f) * 32'h0004_9D37;
  endfunction

  function automatic logic [31:0] expv(input int f, input int ch, input int res);
    return raw(f, ch) & ((32'h1 << res) - 32'h1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input int who, input logic w, input logic [5:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    sel = who; cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    r = (who == 0) ? m_dat : s_dat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input int who, input logic [5:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(who, 1'b1, a, d, dummy);
  endtask

  task automatic rd_chk(input int who, input logic [5:0] a, input logic [31:0] exp,
                        input string req);
    logic [31:0] r;
    bus(who, 1'b0, a, 32'h0, r);
    chk(req, r, exp);
  endtask

  // master-mode transmitter model, drives data on falling bit clock
  always begin
    logic [31:0] v;
    @(negedge m_sck);
    #1;
    if (m_ws !== tx_ws) begin
      tx_ws = m_ws; tx_n++; tx_p = 0;
    end else begin
      tx_p++;
    end
    v = raw(tx_n / 2, tx_n % 2);
    m_sd = (tx_p >= 1 && tx_p <= tx_res) ? v[tx_res - tx_p] : 1'b1;
  end

  task automatic s_bit(input logic ws, input logic sd);
    @(negedge clk);
    s_sck = 1'b0; s_ws = ws; s_sd = sd;
    repeat (S_HALF) @(negedge clk);
    s_sck = 1'b1;
    repeat (S_HALF) @(negedge clk);
  endtask

  task automatic s_slot(input logic ws, input logic [31:0] v, input int res);
    for (int k = 0; k < SLOT_BITS; k++)
      s_bit(ws, (k >= 1 && k <= res) ? v[res - k] : 1'b1);
  endtask

  task automatic test_reset;
    logic [31:0] r;
    chk("R3 irq master", {31'h0, m_irq}, 32'h0);
    chk("R3 irq slave", {31'h0, s_irq}, 32'h0);
    chk("R3 sck/ws low", {30'h0, m_sck, m_ws}, 32'h0);
    rd_chk(0, 6'd1, 32'h0, "R3 config");
    rd_chk(0, 6'd2, 32'h0, "R3 mask");
    rd_chk(0, 6'd3, 32'h0, "R3 status");
    rd_chk(0, 6'd0, 32'h1B1, "R1 version master");
    rd_chk(1, 6'd0, 32'h191, "R1 version slave");
    // R2 acknowledge timing
    @(negedge clk);
    sel = 0; cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 6'd0;
    chk("R2 no ack before edge", {31'h0, m_ack}, 32'h0);
    @(negedge clk);
    chk("R2 ack one cycle later", {31'h0, m_ack}, 32'h1);
    r = m_dat;
    chk("R2 data with ack", r, 32'h1B1);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);
    chk("R2 ack single cycle", {31'h0, m_ack}, 32'h0);
  endtask

  task automatic test_master;
    realtime t0;
    int rises;
    logic w0;
    tx_res = 24; tx_n = 0; tx_p = 0; tx_ws = 1'b0;
    wr(0, 6'd2, 32'h3);
    wr(0, 6'd1, 32'h0018_0001);
    rd_chk(0, 6'd1, 32'h0018_0001, "R1 config readback");
    @(posedge m_sck); t0 = $realtime;
    @(posedge m_sck);
    chk("R4 sck period", 32'(int'(($realtime - t0) / CLK_PERIOD)), 32'(2*SCK_HALF));
    @(m_ws); #1; w0 = m_ws; rises = 0;
    forever begin
      @(posedge m_sck); #1;
      if (m_ws !== w0) break;
      rises++;
    end
    chk("R4 slot length", 32'(rises), 32'(SLOT_BITS));
    wait (m_irq === 1'b1);
    rd_chk(0, 6'd3, 32'h1, "R9 lower half status");
    for (int j = 0; j < 8; j++) begin
      rd_chk(0, 6'(32 + 2*j), expv(j+1, 0, 24), "R7 R8 R6 lower left");
      rd_chk(0, 6'(33 + 2*j), expv(j+1, 1, 24), "R7 R8 R6 lower right");
    end
    wr(0, 6'd3, 32'h1);
    rd_chk(0, 6'd3, 32'h0, "R10 w1c lower");
    chk("R11 irq drops", {31'h0, m_irq}, 32'h0);
    wait (m_irq === 1'b1);
    rd_chk(0, 6'd3, 32'h2, "R9 upper half status");
    for (int j = 8; j < 16; j++) begin
      rd_chk(0, 6'(32 + 2*j), expv(j+1, 0, 24), "R7 upper left");
      rd_chk(0, 6'(33 + 2*j), expv(j+1, 1, 24), "R7 upper right");
    end
    wr(0, 6'd3, 32'h2);
    rd_chk(0, 6'd3, 32'h0, "R10 w1c upper");
    repeat (300) @(negedge clk);
    rd_chk(0, 6'd32, expv(17, 0, 24), "R7 wrap to frame 0");
    wr(0, 6'd1, 32'h0018_0000);
    rd_chk(0, 6'd1, 32'h0018_0000, "R1 config disabled");
    repeat (6) @(negedge clk);
    chk("R12 clocks held low", {30'h0, m_sck, m_ws}, 32'h0);
    tx_n = 0; tx_p = 0; tx_ws = 1'b0;
    wr(0, 6'd1, 32'h0018_0001);
    wait (m_irq === 1'b1);
    rd_chk(0, 6'd32, expv(1, 0, 24), "R12 restart left");
    rd_chk(0, 6'd33, expv(1, 1, 24), "R12 restart right");
    wr(0, 6'd1, 32'h0);
  endtask

  task automatic test_slave;
    wr(1, 6'd2, 32'h0);
    wr(1, 6'd1, 32'h0010_0001);
    s_slot(1'b1, 32'hFFFF_FFFF, 0);
    for (int f = 0; f < 8; f++) begin
      s_slot(1'b0, raw(f, 0), 16);
      s_slot(1'b1, raw(f, 1), 16);
    end
    s_bit(1'b0, 1'b1);
    s_bit(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    rd_chk(1, 6'd3, 32'h1, "R9 slave lower status");
    chk("R11 masked bit no irq", {31'h0, s_irq}, 32'h0);
    wr(1, 6'd2, 32'h1);
    chk("R11 unmasked irq", {31'h0, s_irq}, 32'h1);
    for (int j = 0; j < 8; j++) begin
      rd_chk(1, 6'(32 + 2*j), expv(j, 0, 16), "R5 R6 slave left");
      rd_chk(1, 6'(33 + 2*j), expv(j, 1, 16), "R5 R6 slave right");
    end
    wr(1, 6'd32, 32'hDEAD_BEEF);
    rd_chk(1, 6'd32, expv(0, 0, 16), "R13 buffer write ignored");
    wr(1, 6'd3, 32'h0);
    rd_chk(1, 6'd3, 32'h1, "R10 write zero keeps");
    wr(1, 6'd3, 32'h1);
    rd_chk(1, 6'd3, 32'h0, "R10 slave clear");
    chk("R11 slave irq low", {31'h0, s_irq}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_master();
    test_slave();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule